// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block sits between a small CPU core and its interrupt sources. It watches fourteen maskable peripheral slots, a non-maskable group of three sources (an NMI pin edge, an oscillator fault and a flash access violation) and a reset slot. When the CPU signals an instruction boundary, it chooses the highest-priority request that is pending and enabled. It latches that choice and presents a 16-bit vector address to the CPU. The vector then stays fixed until the CPU acknowledges it.

Priority follows the vector address: slot 15 (reset, 0xFFFE) ranks highest, then slot 14 (the non-maskable group, 0xFFFC), then peripheral slots 13 down to 0. After an acknowledge, the block sends a one-cycle clear pulse to the source it served, but only when that source is marked single-source. It then stays quiet for a fixed acceptance window, which covers the time the CPU spends stacking its state. The flags and enables stay inside the peripherals; the block only reads them.

Top module: `picu_top`

## Requirements
- R1: While `irq_req` is 1, `irq_vec` equals 0xFFE0 plus twice the selected slot index: slots 0..13 map to 0xFFE0..0xFFFA, the NMI group to 0xFFFC and reset to 0xFFFE.
- R2: When several enabled requests are pending at a sampling edge, the slot with the highest index is selected.
- R3: Requests are sampled only on a clock edge where `insn_bnd` is 1. Once `irq_req` is 1, `irq_vec` does not change until the edge on which `irq_ack` is seen.
- R4: When `gie` is 0, peripheral slots 0..13 cannot raise a request.
- R5: A peripheral slot i requests only when both `per_flag[i]` and `per_en[i]` are 1.
- R6: The NMI group requests when any bit of `nmi_flag & nmi_en` is 1, whatever the value of `gie`. `nmi_act` is 1 exactly while the held selection is slot 14.
- R7: In the cycle after the acknowledge edge, `src_clr` carries a one-hot pulse on bit i when the served slot i is single-source. With the default mask 14'h0F0F, slots 0-3 and 8-11 are single-source. For multi-source slots, the NMI group and reset, `src_clr` stays 0.
- R8: After the acknowledge edge, `irq_req` is 0 and `insn_bnd` is ignored for the next ACCEPT_CYC edges (6 by default). A strobe on the 7th edge is sampled.
- R9: After reset, `irq_req` is 1 with `irq_vec` = 0xFFFE, `nmi_act` is 0 and `src_clr` is 0. Acknowledging it produces no clear pulse.
- R10: A strobe with no enabled pending request leaves `irq_req` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| insn_bnd | input | 1 | Instruction-boundary sampling strobe from the CPU |
| gie | input | 1 | Global interrupt enable from the status register |
| per_flag | input | 14 | Pending flags of peripheral slots 0..13 |
| per_en | input | 14 | Per-slot enables of peripheral slots |
| nmi_flag | input | 3 | Non-maskable source flags (pin edge, oscillator fault, flash violation) |
| nmi_en | input | 3 | Per-source enables of the non-maskable group |
| irq_ack | input | 1 | CPU acknowledge of the presented vector |
| irq_req | output | 1 | Request to the CPU |
| irq_vec | output | 16 | Vector address of the held selection |
| nmi_act | output | 1 | Held selection is the non-maskable group |
| src_clr | output | 14 | One-cycle clear pulse to a single-source peripheral flag |

## Verification
Two things can land in the same cycle: the priority decision for a set of competing requests, and the masking by `gie` or by a slot's own enable. The bench sets many flags and enables together, some masked and some not, from a fixed-seed random source plus directed cases. A bench function computes the expected winner on its own, and the bench compares the presented vector and `nmi_act` with it. In a second overlap, new, higher-priority requests arrive while a vector is held, and more arrive during the acceptance window. The bench checks that the held vector does not move, that no request shows before the window ends, and that the clear pulse reaches only single-source slots.

// File: rtl/picu_pkg.sv
package picu_pkg;
  localparam int NPER     = 14;
  localparam int NNMI     = 3;
  localparam int NSLOT    = NPER + 2;
  localparam int IDX_W    = $clog2(NSLOT);
  localparam int VEC_W    = 16;
  localparam int SLOT_NMI = NPER;
  localparam int SLOT_RST = NPER + 1;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HELD = 2'd1,
    ST_BUSY = 2'd2
  } picu_st_t;
endpackage

// File: rtl/picu_cand.sv
module picu_cand
  import picu_pkg::*;
(
  input  logic [NPER-1:0]  per_flag,
  input  logic [NPER-1:0]  per_en,
  input  logic             gie,
  input  logic [NNMI-1:0]  nmi_flag,
  input  logic [NNMI-1:0]  nmi_en,
  output logic [NSLOT-1:0] cand
);
  // peripheral slots: own enable and global enable
  for (genvar i = 0; i < NPER; i++) begin : g_per
    assign cand[i] = per_flag[i] & per_en[i] & gie;
  end
  // non-maskable group: own enables only
  assign cand[SLOT_NMI] = |(nmi_flag & nmi_en);
  // reset slot is raised only by the sequencer's reset state
  assign cand[SLOT_RST] = 1'b0;
endmodule

// File: rtl/picu_prio.sv
module picu_prio
  import picu_pkg::*;
(
  input  logic [NSLOT-1:0] cand,
  output logic             any,
  output logic [IDX_W-1:0] win
);
  always_comb begin
    any = 1'b0;
    win = '0;
    for (int i = 0; i < NSLOT; i++) begin
      if (cand[i]) begin
        any = 1'b1;
        win = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/picu_seq.sv
module picu_seq
  import picu_pkg::*;
#(
  parameter int              ACCEPT_CYC  = 6,
  parameter logic [NPER-1:0] SINGLE_MASK = 14'h0F0F
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             strobe,
  input  logic             any,
  input  logic [IDX_W-1:0] win,
  input  logic             ack,
  output picu_st_t         st,
  output logic [IDX_W-1:0] idx,
  output logic [NPER-1:0]  clr
);
  localparam int CNT_W = $clog2(ACCEPT_CYC + 1);
  localparam logic [NSLOT-1:0] MASK_X = {2'b00, SINGLE_MASK};

  picu_st_t          st_n;
  logic [IDX_W-1:0]  idx_n;
  logic [CNT_W-1:0]  cnt, cnt_n;
  logic [NSLOT-1:0]  clr_full;
  logic [NPER-1:0]   clr_n;

  always_comb begin
    st_n     = st;
    idx_n    = idx;
    cnt_n    = cnt;
    clr_full = '0;
    case (st)
      ST_IDLE: begin
        if (strobe && any) begin
          st_n  = ST_HELD;
          idx_n = win;
        end
      end
      ST_HELD: begin
        if (ack) begin
          st_n  = ST_BUSY;
          cnt_n = CNT_W'(ACCEPT_CYC - 1);
          if (MASK_X[idx]) clr_full = NSLOT'(1) << idx;
        end
      end
      ST_BUSY: begin
        if (cnt == '0) st_n = ST_IDLE;
        else           cnt_n = cnt - CNT_W'(1);
      end
      default: st_n = ST_IDLE;
    endcase
    clr_n = clr_full[NPER-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= ST_HELD;
      idx <= IDX_W'(SLOT_RST);
      cnt <= '0;
      clr <= '0;
    end else begin
      st  <= st_n;
      idx <= idx_n;
      cnt <= cnt_n;
      clr <= clr_n;
    end
  end
endmodule

// File: rtl/picu_top.sv
module picu_top
  import picu_pkg::*;
#(
  parameter int              ACCEPT_CYC  = 6,
  parameter logic [NPER-1:0] SINGLE_MASK = 14'h0F0F,
  parameter logic [15:0]     VEC_BASE    = 16'hFFE0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            insn_bnd,
  input  logic            gie,
  input  logic [13:0]     per_flag,
  input  logic [13:0]     per_en,
  input  logic [2:0]      nmi_flag,
  input  logic [2:0]      nmi_en,
  input  logic            irq_ack,
  output logic            irq_req,
  output logic [15:0]     irq_vec,
  output logic            nmi_act,
  output logic [13:0]     src_clr
);
  logic [1:0]       rst_sync;
  logic             rst_int_n;
  logic [NSLOT-1:0] cand;
  logic             any;
  logic [IDX_W-1:0] win;
  picu_st_t         st;
  logic [IDX_W-1:0] idx;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= '0;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  picu_cand u_cand (
    .per_flag (per_flag),
    .per_en   (per_en),
    .gie      (gie),
    .nmi_flag (nmi_flag),
    .nmi_en   (nmi_en),
    .cand     (cand)
  );

  picu_prio u_prio (
    .cand (cand),
    .any  (any),
    .win  (win)
  );

  picu_seq #(
    .ACCEPT_CYC  (ACCEPT_CYC),
    .SINGLE_MASK (SINGLE_MASK)
  ) u_seq (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .strobe (insn_bnd),
    .any    (any),
    .win    (win),
    .ack    (irq_ack),
    .st     (st),
    .idx    (idx),
    .clr    (src_clr)
  );

  assign irq_req = (st == ST_HELD);
  assign irq_vec = VEC_BASE + (VEC_W'(idx) << 1);
  assign nmi_act = irq_req && (idx == IDX_W'(SLOT_NMI));
endmodule

// File: rtl/picu_chk.sv
module picu_chk #(
  parameter int ACCEPT_CYC = 6
) (
  input logic        clk,
  input logic        rst_n,
  input logic        irq_req,
  input logic        irq_ack,
  input logic [15:0] irq_vec,
  input logic        nmi_act,
  input logic [13:0] src_clr
);
  localparam int CW = $clog2(ACCEPT_CYC + 2);
  logic [CW-1:0] since_ack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  since_ack <= CW'(ACCEPT_CYC + 1);
    else if (irq_req && irq_ack) since_ack <= '0;
    else if (since_ack != CW'(ACCEPT_CYC + 1)) since_ack <= since_ack + CW'(1);
  end

  p_vec_in_table_r1: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (irq_vec[15:5] == 11'h7FF && irq_vec[0] == 1'b0));

  p_vec_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && !irq_ack) |=> (irq_req && $stable(irq_vec)));

  p_nmi_vec_r6: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_act |-> (irq_req && irq_vec == 16'hFFFC));

  p_clr_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(src_clr));

  p_clr_after_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (src_clr != '0) |-> $past(irq_req && irq_ack));

  p_drop_on_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && irq_ack) |=> !irq_req);

  p_quiet_window_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (since_ack < CW'(ACCEPT_CYC)) |-> !irq_req);
endmodule

bind picu_top picu_chk #(.ACCEPT_CYC(ACCEPT_CYC)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .irq_req (irq_req),
  .irq_ack (irq_ack),
  .irq_vec (irq_vec),
  .nmi_act (nmi_act),
  .src_clr (src_clr)
);

// File: tb/tb_picu_top.sv
module tb_picu_top;
  localparam int CLK_PERIOD = 10;
  localparam int ACC = 6;
  localparam logic [13:0] SMASK = 14'h0F0F;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        insn_bnd, gie, irq_ack;
  logic [13:0] per_flag, per_en;
  logic [2:0]  nmi_flag, nmi_en;
  logic        irq_req, nmi_act;
  logic [15:0] irq_vec;
  logic [13:0] src_clr;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  picu_top dut (
    .clk(clk), .rst_n(rst_n), .insn_bnd(insn_bnd), .gie(gie),
    .per_flag(per_flag), .per_en(per_en), .nmi_flag(nmi_flag),
    .nmi_en(nmi_en), .irq_ack(irq_ack), .irq_req(irq_req),
    .irq_vec(irq_vec), .nmi_act(nmi_act), .src_clr(src_clr)
  );

  function automatic int exp_win(logic [13:0] f, logic [13:0] e, logic g,
                                 logic [2:0] nf, logic [2:0] ne);
    if ((nf & ne) != 3'b0) return 14;
    if (g) for (int i = 13; i >= 0; i--) if (f[i] && e[i]) return i;
    return -1;
  endfunction

  function automatic logic [15:0] exp_vec(int w);
    return 16'hFFE0 + 16'(2 * w);
  endfunction

  function automatic logic [13:0] exp_clr(int w);
    if (w < 14 && SMASK[w]) return 14'(1) << w;
    return 14'h0;
  endfunction

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  // acknowledge the held vector, check the clear pulse and the quiet window
  task automatic ack_and_wait(int w);
    irq_ack = 1'b1;
    cyc();
    irq_ack = 1'b0;
    chk(src_clr == exp_clr(w), "R7 clear pulse", 32'(src_clr), 32'(exp_clr(w)));
    chk(!irq_req, "R8 request drops on ack", 32'(irq_req), 0);
    insn_bnd = 1'b1;
    for (int k = 1; k < ACC; k++) begin
      cyc();
      chk(!irq_req, "R8 strobe ignored in window", 32'(irq_req), 0);
      if (k == 1) chk(src_clr == 14'h0, "R7 pulse lasts one cycle", 32'(src_clr), 0);
    end
    cyc();
    chk(!irq_req, "R8 strobe ignored at last window edge", 32'(irq_req), 0);
    insn_bnd = 1'b0;
  endtask

  task automatic go(logic [13:0] f, logic [13:0] e, logic g,
                    logic [2:0] nf, logic [2:0] ne, string tag);
    int w;
    per_flag = f; per_en = e; gie = g; nmi_flag = nf; nmi_en = ne;
    insn_bnd = 1'b1;
    cyc();
    insn_bnd = 1'b0;
    w = exp_win(f, e, g, nf, ne);
    if (w < 0) begin
      chk(!irq_req, {tag, " / R10 no request"}, 32'(irq_req), 0);
    end else begin
      chk(irq_req, {tag, " request"}, 32'(irq_req), 1);
      chk(irq_vec == exp_vec(w), {tag, " / R1 vector"}, 32'(irq_vec), 32'(exp_vec(w)));
      chk(nmi_act == (w == 14), "R6 nmi_act", 32'(nmi_act), 32'(w == 14));
      ack_and_wait(w);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [13:0] rf, re;
    logic [2:0]  rnf, rne;
    void'($urandom(32'd4711));
    rst_n = 1'b0; insn_bnd = 1'b0; gie = 1'b0; irq_ack = 1'b0;
    per_flag = '0; per_en = '0; nmi_flag = '0; nmi_en = '0;
    repeat (3) cyc();
    rst_n = 1'b1;
    repeat (3) cyc();

    // R9 reset vector presented
    chk(irq_req, "R9 reset request", 32'(irq_req), 1);
    chk(irq_vec == 16'hFFFE, "R9 reset vector", 32'(irq_vec), 32'hFFFE);
    chk(!nmi_act, "R9 nmi_act low", 32'(nmi_act), 0);
    chk(src_clr == 14'h0, "R9 no clear", 32'(src_clr), 0);
    ack_and_wait(15);

    // R2 priority
    go(14'h3FFF, 14'h3FFF, 1'b1, 3'b0, 3'b0, "R2 all pending");
    go(14'h0021, 14'h3FFF, 1'b1, 3'b0, 3'b0, "R2 slots 0 and 5");
    // R4 global mask
    go(14'h3FFF, 14'h3FFF, 1'b0, 3'b0, 3'b0, "R4 gie low");
    // R6 NMI ignores gie, obeys own enable
    go(14'h3FFF, 14'h3FFF, 1'b0, 3'b010, 3'b011, "R6 nmi with gie low");
    go(14'h0008, 14'h3FFF, 1'b1, 3'b111, 3'b000, "R6 nmi disabled");
    // R5 per-slot enable
    go(14'h0204, 14'h0004, 1'b1, 3'b0, 3'b0, "R5 slot 9 disabled");
    // R7 multi-source slot 4 and single-source slot 0
    go(14'h0010, 14'h0010, 1'b1, 3'b0, 3'b0, "R7 multi-source");
    go(14'h0001, 14'h0001, 1'b1, 3'b0, 3'b0, "R7 single-source");

    // R3 no sampling without the strobe, then hold
    per_flag = 14'h0008; per_en = 14'h3FFF; gie = 1'b1;
    nmi_flag = '0; nmi_en = '0; insn_bnd = 1'b0;
    repeat (3) cyc();
    chk(!irq_req, "R3 no strobe no request", 32'(irq_req), 0);
    insn_bnd = 1'b1;
    cyc();
    chk(irq_vec == 16'hFFE6, "R3 strobed vector", 32'(irq_vec), 32'hFFE6);
    per_flag = 14'h1008; nmi_flag = 3'b001; nmi_en = 3'b001;
    repeat (2) cyc();
    chk(irq_req && irq_vec == 16'hFFE6, "R3 vector held", 32'(irq_vec), 32'hFFE6);
    insn_bnd = 1'b0;
    nmi_flag = '0;
    ack_and_wait(3);

    // random mix
    for (int it = 0; it < 60; it++) begin
      rf  = 14'($urandom);
      re  = 14'($urandom);
      rnf = (($urandom % 4) == 0) ? 3'($urandom) : 3'b0;
      rne = 3'($urandom);
      go(rf, re, 1'($urandom), rnf, rne, "R2 random");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule